// File: doc/BRIEF.md
# Pipelined Burst SRAM Control Front End

This block is the synchronous control front end of a pipelined burst SRAM, together with a small internal array. On every rising clock edge it samples three chip selects, two address strobes, the address, an advance input and the write controls. A strobe seen while the device is selected opens a new access. The address is registered, and its two low bits seed a two-bit burst counter that supplies the low word address while the access runs. A strobe seen while the device is not selected closes the access.

Once an access is open, each later edge without a strobe is a data slot. A slot with a decoded write stores `din` into the current word, and the write can cover all lanes or only some of them. A slot without a write is a read. Read data is registered and appears one clock after the address that produced it. The bus enable `dq_en` is an asynchronous function of the active-low output enable and the registered read state. It is held off for the first clock after an access opens from the idle state.

Top module: `burst_sram_fe`

## Requirements
- R1: A strobe opens an access only when the device is selected (`ce1_n`=0, `ce2`=1, `ce3_n`=0) on that edge. The strobe is either `adsp_n`=0 with `ce1_n`=0, or `adsc_n`=0. The address is captured on that same edge.
- R2: A strobe seen while the device is not selected closes the access. The bus then stays undriven until a later access opens.
- R3: `adsp_n` has no effect while `ce1_n`=1. With `adsc_n`=1 on such an edge, an open burst simply continues as if no strobe were present.
- R4: The registered upper address bits stay fixed for the whole access. The word address is {upper bits, counter}, and the counter is loaded from `addr[1:0]`.
- R5: On a non-strobe edge of an open access, `adv_n`=0 steps the counter by one in linear order and wraps modulo 4. `adv_n`=1 holds the counter.
- R6: In a slot, `gw_n`=0 writes every lane of the current word, whatever the values of `bwe_n` and `bw_n`.
- R7: In a slot with `gw_n`=1 and `bwe_n`=0, lane i (`din[8i+7:8i]`) is written only when `bw_n[i]`=0. With no lane selected, or with `bwe_n`=1, the slot is a read.
- R8: After a read slot or a load edge, `dq_out` holds the word at the address that was current before that edge, which is one clock of pipeline latency.
- R9: `dq_en` is 0 whenever `oe_n`=1, and it follows `oe_n` without waiting for a clock.
- R10: For one clock after an access opens from the idle state, `dq_en` stays 0 even with `oe_n`=0. A load that replaces an open access is not masked.
- R11: After reset, after a write slot, and while no access is open, `dq_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ce1_n | input | 1 | Select, active low; also gates `adsp_n` |
| ce2 | input | 1 | Select, active high |
| ce3_n | input | 1 | Select, active low |
| adsp_n | input | 1 | Address strobe gated by `ce1_n`, active low |
| adsc_n | input | 1 | Address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| addr | input | AW | Word address |
| gw_n | input | 1 | Write all lanes, active low |
| bwe_n | input | 1 | Lane-write enable, active low |
| bw_n | input | NB | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | DW | Write data |
| dq_out | output | DW | Registered read data |
| dq_en | output | 1 | Bus drive enable for `dq_out` |

## Verification
The embedded properties are checked on every cycle. They cover counter stepping and holding, fixed upper bits, the inert `adsp_n` while `ce1_n` is high, all-lane writes under `gw_n`, the mask after an idle load, the undriven bus after writes, when idle and with `oe_n` high. Data correctness is shown only by the bench scenarios, which compare against a reference array. These cover full-array burst writes and reads from every starting offset, every lane pattern, restart of an open access, rejected select combinations, and `oe_n` toggled in the middle of a cycle.

// File: rtl/burst_fe_pkg.sv
package burst_fe_pkg;
  // strobe outcome on one edge
  typedef enum logic [1:0] {
    STB_NONE  = 2'd0,
    STB_LOAD  = 2'd1,
    STB_CLOSE = 2'd2
  } strobe_e;

  function automatic logic chip_selected(input logic c1_n, input logic c2, input logic c3_n);
    return !c1_n && c2 && !c3_n;
  endfunction
endpackage

// File: rtl/fe_select.sv
module fe_select
  import burst_fe_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ce1_n,
  input  logic ce2,
  input  logic ce3_n,
  input  logic adsp_n,
  input  logic adsc_n,
  output logic strobe,
  output logic load,
  output logic open_from_idle,
  output logic act_q
);
  strobe_e outcome;
  logic    p_hit;
  logic    c_hit;

  always_comb begin
    p_hit   = !adsp_n && !ce1_n;
    c_hit   = !adsc_n && !p_hit;
    outcome = STB_NONE;
    if (p_hit || c_hit)
      outcome = chip_selected(ce1_n, ce2, ce3_n) ? STB_LOAD : STB_CLOSE;
  end

  assign strobe         = (outcome != STB_NONE);
  assign load           = (outcome == STB_LOAD);
  assign open_from_idle = load && !act_q;

  always_ff @(posedge clk) begin
    if (rst)                    act_q <= 1'b0;
    else if (outcome == STB_LOAD)  act_q <= 1'b1;
    else if (outcome == STB_CLOSE) act_q <= 1'b0;
  end

  AST_CLOSE_ENDS: assert property (@(posedge clk) disable iff (rst)
    (strobe && !load) |=> !act_q); // R2
endmodule

// File: rtl/fe_burst_addr.sv
module fe_burst_addr #(
  parameter int AW = 8,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] cur_addr
);
  localparam int UW = AW - CW;

  logic [UW-1:0] up_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q  <= '0;
      cnt_q <= '0;
    end else if (load) begin
      up_q  <= addr[AW-1:CW];
      cnt_q <= addr[CW-1:0];
    end else if (step) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign cur_addr = {up_q, cnt_q};

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!load && step) |=> (cnt_q == $past(cnt_q) + CW'(1))); // R5
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(cnt_q)); // R5
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(up_q)); // R4
endmodule

// File: rtl/fe_write_decode.sv
module fe_write_decode #(
  parameter int NB = 2
) (
  input  logic          slot,
  input  logic          gw_n,
  input  logic          bwe_n,
  input  logic [NB-1:0] bw_n,
  output logic [NB-1:0] lane_we,
  output logic          wr_any
);
  logic [NB-1:0] pick;

  always_comb begin
    if (!gw_n)       pick = '1;
    else if (!bwe_n) pick = ~bw_n;
    else             pick = '0;
  end

  assign lane_we = slot ? pick : '0;
  assign wr_any  = |pick;
endmodule

// File: rtl/fe_mem_array.sv
module fe_mem_array #(
  parameter int AW = 8,
  parameter int LW = 8,
  parameter int NB = 2
) (
  input  logic           clk,
  input  logic [NB-1:0]  we,
  input  logic [AW-1:0]  addr,
  input  logic [NB*LW-1:0] wdata,
  output logic [NB*LW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[g]) mem[addr] <= wdata[g*LW +: LW];
      rdata[g*LW +: LW] <= mem[addr];
    end
  end
endmodule

// File: rtl/fe_out_stage.sv
module fe_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic rd_next,
  input  logic mask_next,
  input  logic oe_n,
  output logic dq_en
);
  logic rd_q;
  logic mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      rd_q   <= rd_next;
      mask_q <= mask_next;
    end
  end

  assign dq_en = !oe_n && rd_q && !mask_q;
endmodule

// File: rtl/burst_sram_fe.sv
module burst_sram_fe #(
  parameter int AW = 8,
  parameter int LW = 8,
  parameter int NB = 2,
  parameter int CW = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             adsp_n,
  input  logic             adsc_n,
  input  logic             adv_n,
  input  logic [AW-1:0]    addr,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [NB-1:0]    bw_n,
  input  logic             oe_n,
  input  logic [NB*LW-1:0] din,
  output logic [NB*LW-1:0] dq_out,
  output logic             dq_en
);
  localparam int DW = NB * LW;

  logic          strobe;
  logic          load;
  logic          from_idle;
  logic          act_q;
  logic          slot;
  logic [AW-1:0] cur_addr;
  logic [NB-1:0] lane_we;
  logic          wr_any;
  logic [DW-1:0] rdata;

  fe_select u_sel (
    .clk(clk), .rst(rst), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .strobe(strobe), .load(load),
    .open_from_idle(from_idle), .act_q(act_q)
  );

  assign slot = act_q && !strobe;

  fe_burst_addr #(.AW(AW), .CW(CW)) u_addr (
    .clk(clk), .rst(rst), .load(load), .step(slot && !adv_n),
    .addr(addr), .cur_addr(cur_addr)
  );

  fe_write_decode #(.NB(NB)) u_wdec (
    .slot(slot), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .lane_we(lane_we), .wr_any(wr_any)
  );

  fe_mem_array #(.AW(AW), .LW(LW), .NB(NB)) u_mem (
    .clk(clk), .we(lane_we), .addr(cur_addr), .wdata(din), .rdata(rdata)
  );

  fe_out_stage u_out (
    .clk(clk), .rst(rst),
    .rd_next(load || (slot && !wr_any)),
    .mask_next(from_idle),
    .oe_n(oe_n), .dq_en(dq_en)
  );

  assign dq_out = rdata;

  AST_ADSP_INERT: assert property (@(posedge clk) disable iff (rst)
    (ce1_n && adsc_n) |=> ($stable(act_q) && $stable(cur_addr[AW-1:CW]))); // R3
  AST_GW_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
    (slot && !gw_n) |-> (lane_we == {NB{1'b1}})); // R6
  AST_IDLE_MASK: assert property (@(posedge clk) disable iff (rst)
    from_idle |=> !dq_en); // R10
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (slot && wr_any) |=> !dq_en); // R11
  AST_CLOSED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !act_q |-> !dq_en); // R2
  AST_OE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !dq_en); // R9
endmodule

// File: tb/burst_sram_fe_bench.sv
module burst_sram_fe_bench;
  localparam int AW = 8;
  localparam int NB = 2;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n, oe_n;
  logic [AW-1:0] addr;
  logic [NB-1:0] bw_n;
  logic [DW-1:0] din;
  logic [DW-1:0] dq_out;
  logic dq_en;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  logic [DW-1:0] ref_mem [1 << AW];
  bit            m_act = 0;
  logic [AW-1:0] m_cur = '0;
  bit            m_rd = 0;
  bit            m_mask = 0;
  logic [DW-1:0] m_data = '0;

  always #5 clk = ~clk;

  burst_sram_fe u_burst_sram_fe (
    .clk(clk), .rst(rst), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .addr(addr),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .din(din),
    .dq_out(dq_out), .dq_en(dq_en)
  );

  task automatic check_bus(input string tag);
    bit exp_en;
    exp_en = m_rd && !m_mask && !oe_n;
    total++;
    if (dq_en !== exp_en) begin
      bad++;
      $display("FAIL %s: dq_en=%0b expected %0b", tag, dq_en, exp_en);
    end else if (exp_en) begin
      total++;
      if (dq_out !== m_data) begin
        bad++;
        $display("FAIL %s: dq_out=%h expected %h", tag, dq_out, m_data);
      end
    end
  endtask

  // one clock: update the model from the requirements, then check
  task automatic step(input string tag);
    bit sp, sc, st, sel, slot, wr;
    logic [NB-1:0] lanes;
    @(posedge clk);
    sp  = !adsp_n && !ce1_n;                 // R3: adsp gated by ce1
    sc  = !adsc_n && !sp;
    st  = sp || sc;
    sel = !ce1_n && ce2 && !ce3_n;           // R1
    slot = m_act && !st;
    if (!gw_n) lanes = '1;                   // R6
    else if (!bwe_n) lanes = ~bw_n;          // R7
    else lanes = '0;
    wr = slot && (lanes != '0);
    m_data = ref_mem[m_cur];                 // R8: read before write
    if (wr)
      for (int i = 0; i < NB; i++)
        if (lanes[i]) ref_mem[m_cur][i*8 +: 8] = din[i*8 +: 8];
    m_mask = st && sel && !m_act;            // R10
    m_rd   = (st && sel) || (slot && !wr);   // R11
    if (st && sel) m_cur = addr;             // R4
    else if (slot && !adv_n) m_cur[1:0] = m_cur[1:0] + 2'd1;  // R5
    if (st) m_act = sel;                     // R2
    @(negedge clk);
    check_bus(tag);
  endtask

  task automatic quiet();
    ce1_n = 1'b1; ce2 = 1'b0; ce3_n = 1'b1;
    adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1;
  endtask

  task automatic open_at(input logic [AW-1:0] a, input bit use_c, input string tag);
    quiet();
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    addr = a;
    if (use_c) adsc_n = 1'b0; else adsp_n = 1'b0;
    step(tag);
    quiet();
  endtask

  task automatic close_it();
    quiet();
    adsc_n = 1'b0;                           // ce2 low: not selected
    step("R2");
    quiet();
  endtask

  initial begin
    quiet();
    oe_n = 1'b0; addr = '0; din = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_bus("R11");                        // reset: bus undriven

    // full-array burst writes, every start offset (R6, R11)
    for (int g = 0; g < 64; g++) begin
      open_at(AW'(g * 4 + (g % 4)), g[0], "R10");
      for (int k = 0; k < 4; k++) begin
        gw_n = 1'b0; bwe_n = (k % 2 == 0); bw_n = NB'(k);
        adv_n = 1'b0; din = DW'(g * 977 + k * 131 + 16'h1a2b);
        step("R11");
      end
      close_it();
    end

    // full-array burst reads with wrap (R4, R5, R8)
    for (int g = 0; g < 64; g++) begin
      open_at(AW'(g * 4 + 3 - (g % 4)), !g[0], "R10");
      for (int k = 0; k < 4; k++) begin
        adv_n = 1'b0;
        step("R4");
      end
      close_it();
    end

    // lane writes, every lane pattern (R7), then all-lane override (R6)
    for (int g = 0; g < 16; g++) begin
      open_at(AW'(g * 4), 1'b1, "R10");
      for (int k = 0; k < 4; k++) begin
        bwe_n = 1'b0; bw_n = NB'(k); adv_n = 1'b0;
        din = DW'(16'hc3a5 ^ (g * 4 + k) * 16'h0101);
        step("R7");
      end
      gw_n = 1'b0; bwe_n = 1'b1; bw_n = '1; din = DW'(16'h5a00 + g);
      step("R6");
      gw_n = 1'b1; bwe_n = 1'b1; bw_n = '0; adv_n = 1'b0;
      step("R7");
      quiet();
      for (int k = 0; k < 4; k++) begin
        adv_n = 1'b0;
        step("R7");
      end
      close_it();
    end

    // advance hold and asynchronous output enable (R5, R9)
    open_at(8'h41, 1'b0, "R10");
    for (int k = 0; k < 3; k++) step("R5");
    oe_n = 1'b1; #1; check_bus("R9");
    adv_n = 1'b0; step("R9");
    oe_n = 1'b0; #1; check_bus("R9");
    step("R5");

    // adsp ignored with ce1 high, burst continues (R3)
    quiet();
    adsp_n = 1'b0; adv_n = 1'b0; addr = 8'h90;
    step("R3");
    step("R3");
    // adsc with ce1 high closes the access (R2)
    quiet(); adsc_n = 1'b0;
    step("R2");
    quiet();
    step("R2"); step("R2");

    // select gating (R1)
    open_at(8'h22, 1'b1, "R1");
    adv_n = 1'b0; step("R1");
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b1; adsc_n = 1'b0; addr = 8'h77;
    step("R1");
    quiet(); step("R1");
    open_at(8'h30, 1'b0, "R1");
    ce1_n = 1'b0; ce2 = 1'b0; ce3_n = 1'b0; adsp_n = 1'b0;
    step("R1");
    quiet(); step("R1");

    // restart while open: no mask, pipelined old word (R1, R8, R10)
    open_at(8'hA6, 1'b0, "R10");
    adv_n = 1'b0; step("R8");
    open_at(8'h13, 1'b1, "R10");
    adv_n = 1'b0; step("R8");
    step("R8");
    close_it();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule